// File: doc/BRIEF.md
# Flash Sector Write-Protection Gate

This block sits between the command decoder of a boot-sector flash controller and its embedded program/erase engine. It decides, for every program or erase request, whether the targeted sector may be modified. Each sector has a soft lock bit. Decoded lock and unlock commands set and clear these bits. The soft bits are combined with two active-low hardware pins. The write-protect pin guards the boot sectors, which sit at the bottom or the top of the sector range depending on a boot-orientation input. The acceleration pin guards every sector.

Requests arrive on a valid/ready stream. The decoder marks each request as armed when the unlock command cycles that must come before it were seen. An armed request that passes every check goes out on a second valid/ready stream that starts the embedded operation. An armed request that fails any check produces a one-cycle reject pulse and updates a sticky deny flag. An unarmed request is taken off the input stream and has no effect. The input is ready whenever the output stage is empty or its content is being taken in the same cycle. A granted operation stays on the output, unchanged, until the engine accepts it.

Top module: `wp_sector_guard`

## Requirements
- R1: After reset every soft lock bit is set, `op_valid`, `reject` and `deny` are 0, and an armed request to any sector is therefore rejected.
- R2: With `cmd_valid` high, `cmd_lock`=1 sets and `cmd_lock`=0 clears the lock bit of `cmd_sector` at the clock edge. A command with `cmd_sector` >= NUM_SECT changes nothing.
- R3: An accepted armed request to an unlocked, unprotected sector raises `op_valid` on the next cycle, with `op_sector` equal to the request sector and `op_erase` equal to `req_erase` (0 = program, 1 = erase). No reject pulse is produced.
- R4: An accepted armed request to a sector whose lock bit is set raises `reject` for exactly the next cycle and does not start an operation. Grant and reject never occur for the same request.
- R5: With `wp_n`=0 and `boot_top`=0, sectors 0 to BOOT_SECT-1 are denied whatever their lock bits are. Other sectors are not affected.
- R6: With `wp_n`=0 and `boot_top`=1, sectors NUM_SECT-BOOT_SECT to NUM_SECT-1 are denied. Sectors at the bottom are not affected.
- R7: With `acc_n`=0, every sector is denied.
- R8: An accepted request with `req_armed`=0 produces no operation and no reject, and leaves `deny` unchanged.
- R9: `req_ready` = !`op_valid` | `op_ready`. While `op_valid`=1 and `op_ready`=0, `op_valid`, `op_sector` and `op_erase` hold their values.
- R10: `deny` is 1 when the most recent accepted armed request was denied, and 0 when it was granted.
- R11: An armed request with `req_sector` >= NUM_SECT is denied.
- R12: When a lock command and an accepted request fall in the same cycle, the request is judged against the lock bit as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_top | input | 1 | 1 = boot sectors at top of range, 0 = at bottom |
| wp_n | input | 1 | Active-low write-protect pin for the boot sectors |
| acc_n | input | 1 | Active-low acceleration pin; low locks all sectors |
| cmd_valid | input | 1 | Decoded lock/unlock command strobe |
| cmd_lock | input | 1 | 1 = lock, 0 = unlock |
| cmd_sector | input | SW | Sector targeted by the command |
| req_valid | input | 1 | Program/erase request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_armed | input | 1 | Unlock cycles were seen before this request |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_sector | input | SW | Sector targeted by the request |
| op_valid | output | 1 | Granted operation valid |
| op_ready | input | 1 | Embedded engine takes the operation |
| op_sector | output | SW | Sector of the granted operation |
| op_erase | output | 1 | Kind of the granted operation |
| reject | output | 1 | One-cycle pulse for a denied armed request |
| deny | output | 1 | Result of the latest armed request, 1 = denied |

## Verification
The bench builds the block with its default values, NUM_SECT = 134 and BOOT_SECT = 2, so SW is 8. This reaches both boot zones at their real places: sectors 0 and 1 at the bottom, and sectors 132 and 133 at the top. It also reaches the sectors just outside each zone, 2 and 131. Because SW is 8, sector codes from 134 to 255 can be driven, which exercises out-of-range commands and requests. Holding back op_ready brings the back-pressure hold and the stalled-input cases within reach.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    KIND_PROG  = 1'b0,
    KIND_ERASE = 1'b1
  } op_kind_e;

  function automatic logic in_range(input int unsigned sect, input int unsigned n);
    return sect < n;
  endfunction
endpackage

// File: rtl/wp_lock_bank.sv
module wp_lock_bank #(
  parameter int NUM_SECT = 134,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sector,
  input  logic          wr_lock,
  input  logic [SW-1:0] rd_sector,
  output logic          rd_locked
);
  logic [NUM_SECT-1:0] lock_q;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[g] <= 1'b1;
      else if (wr_en && wr_sector == SW'(g)) lock_q[g] <= wr_lock;
    end
  end

  always_comb begin
    rd_locked = 1'b1;
    for (int i = 0; i < NUM_SECT; i++)
      if (rd_sector == SW'(i)) rd_locked = lock_q[i];
  end

  p_lock_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp_pkg::in_range(32'(wr_sector), NUM_SECT))
      |=> (lock_q[$past(wr_sector)] == $past(wr_lock)));
endmodule

// File: rtl/wp_pin_qual.sv
module wp_pin_qual #(
  parameter int NUM_SECT = 134,
  parameter int BOOT_SECT = 2,
  parameter int SW = 8
) (
  input  logic [SW-1:0] sector,
  input  logic          boot_top,
  input  logic          wp_n,
  input  logic          acc_n,
  output logic          hw_deny
);
  localparam int TOP_BASE = NUM_SECT - BOOT_SECT;

  logic valid_idx, in_bottom, in_top, boot_zone;

  always_comb begin
    valid_idx = wp_pkg::in_range(32'(sector), NUM_SECT);
    in_bottom = 32'(sector) < BOOT_SECT;
    in_top    = valid_idx && (32'(sector) >= TOP_BASE);
    boot_zone = boot_top ? in_top : in_bottom;
    hw_deny   = !valid_idx || !acc_n || (!wp_n && boot_zone);
  end
endmodule

// File: rtl/wp_decide.sv
module wp_decide #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          allow,
  input  logic [SW-1:0] sector,
  input  logic          erase,
  input  logic          op_ready,
  output logic          slot_free,
  output logic          op_valid,
  output logic [SW-1:0] op_sector,
  output logic          op_erase,
  output logic          reject,
  output logic          deny
);
  import wp_pkg::*;

  op_kind_e kind_q;
  logic     valid_q;

  assign slot_free = !valid_q || op_ready;
  assign op_valid  = valid_q;
  assign op_erase  = (kind_q == KIND_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      op_sector <= '0;
      kind_q    <= KIND_PROG;
      reject    <= 1'b0;
      deny      <= 1'b0;
    end else begin
      reject <= fire && !allow;
      if (fire) deny <= !allow;
      if (fire && allow) begin
        valid_q   <= 1'b1;
        op_sector <= sector;
        kind_q    <= erase ? KIND_ERASE : KIND_PROG;
      end else if (op_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  p_op_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_sector) && $stable(op_erase)));
  p_grant_xor_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> !reject);
endmodule

// File: rtl/wp_sector_guard.sv
module wp_sector_guard #(
  parameter int NUM_SECT = 134,
  parameter int BOOT_SECT = 2,
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_top,
  input  logic          wp_n,
  input  logic          acc_n,
  input  logic          cmd_valid,
  input  logic          cmd_lock,
  input  logic [SW-1:0] cmd_sector,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_armed,
  input  logic          req_erase,
  input  logic [SW-1:0] req_sector,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [SW-1:0] op_sector,
  output logic          op_erase,
  output logic          reject,
  output logic          deny
);
  logic soft_locked, hw_deny, fire, allow;

  wp_lock_bank #(.NUM_SECT(NUM_SECT), .SW(SW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmd_valid), .wr_sector(cmd_sector), .wr_lock(cmd_lock),
    .rd_sector(req_sector), .rd_locked(soft_locked)
  );

  wp_pin_qual #(.NUM_SECT(NUM_SECT), .BOOT_SECT(BOOT_SECT), .SW(SW)) u_pins (
    .sector(req_sector), .boot_top(boot_top), .wp_n(wp_n), .acc_n(acc_n),
    .hw_deny(hw_deny)
  );

  assign fire  = req_valid && req_ready && req_armed;
  assign allow = !soft_locked && !hw_deny;

  wp_decide #(.SW(SW)) u_decide (
    .clk(clk), .rst_n(rst_n), .fire(fire), .allow(allow),
    .sector(req_sector), .erase(req_erase), .op_ready(op_ready),
    .slot_free(req_ready), .op_valid(op_valid), .op_sector(op_sector),
    .op_erase(op_erase), .reject(reject), .deny(deny)
  );

  p_acc_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_armed && !acc_n) |=> reject);
  p_wp_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_armed && !wp_n && !boot_top
     && 32'(req_sector) < BOOT_SECT) |=> reject);
  p_wp_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_armed && !wp_n && boot_top
     && 32'(req_sector) >= NUM_SECT - BOOT_SECT) |=> reject);
  p_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_armed) |=> (!reject && $stable(deny)));
  p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_armed && 32'(req_sector) >= NUM_SECT) |=> reject);
endmodule

// File: tb/tb_wp_sector_guard.sv
module tb_wp_sector_guard;
  localparam int N = 134;
  localparam int B = 2;
  localparam int SW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, boot_top, wp_n, acc_n, cmd_valid, cmd_lock, req_valid, req_armed, req_erase, op_ready;
  logic [SW-1:0] cmd_sector, req_sector;
  logic req_ready, op_valid, op_erase, reject, deny;
  logic [SW-1:0] op_sector;

  wp_sector_guard dut (.*);

  int n_cmp = 0, n_bad = 0;
  string cur = "R1";
  bit m_lock[N];
  bit m_opv, m_ope, m_rej, m_deny;
  int m_ops;
  bit done = 0;

  task automatic chk(string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur, sig, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit rdy, acc, ok, zone;
    #1;
    rdy = !m_opv || op_ready;
    if (rst_n) chk("req_ready(R9)", req_ready, rdy);
    acc = rst_n && req_valid && rdy && req_armed;
    zone = boot_top ? (req_sector >= N - B && req_sector < N) : (req_sector < B);
    ok = (req_sector < N) && acc_n && !(!wp_n && zone);
    if (ok) ok = !m_lock[req_sector];
    if (!rst_n) begin
      foreach (m_lock[i]) m_lock[i] = 1;
      m_opv = 0; m_ope = 0; m_rej = 0; m_deny = 0; m_ops = 0;
    end else begin
      m_rej = acc && !ok;
      if (acc) m_deny = !ok;
      if (acc && ok) begin m_opv = 1; m_ops = req_sector; m_ope = req_erase; end
      else if (op_ready) m_opv = 0;
      if (cmd_valid && cmd_sector < N) m_lock[cmd_sector] = cmd_lock;
    end
    @(posedge clk); #1;
    chk("op_valid(R3)", op_valid, m_opv);
    if (m_opv) begin
      chk("op_sector(R3)", op_sector, m_ops);
      chk("op_erase(R3)", op_erase, m_ope);
    end
    chk("reject(R4)", reject, m_rej);
    chk("deny(R10)", deny, m_deny);
    @(negedge clk);
    cmd_valid = 0; req_valid = 0;
  endtask

  task automatic cmd(bit lk, int s);
    cmd_valid = 1; cmd_lock = lk; cmd_sector = SW'(s); cyc();
  endtask

  task automatic req(int s, bit er, bit armed = 1);
    req_valid = 1; req_armed = armed; req_erase = er; req_sector = SW'(s); cyc();
  endtask

  initial begin
    rst_n = 0; boot_top = 0; wp_n = 1; acc_n = 1; cmd_valid = 0; cmd_lock = 0;
    cmd_sector = 0; req_valid = 0; req_armed = 0; req_erase = 0; req_sector = 0; op_ready = 1;
    @(negedge clk);
    cur = "R1"; cyc(); cyc();
    rst_n = 1; cyc();
    req(5, 0); req(133, 1); cyc();
    cur = "R2"; cmd(0, 5); req(5, 0); cmd(0, 200); req(5, 1); cmd(1, 5); req(5, 0); cmd(0, 5);
    cur = "R3"; cmd(0, 70); req(70, 1); req(5, 0); req(70, 0); cyc();
    cur = "R4"; req(6, 1); req(7, 0); req(5, 1); cyc();
    cur = "R5"; cmd(0, 0); cmd(0, 1); cmd(0, 2); wp_n = 0;
    req(0, 0); req(1, 1); req(2, 0); req(70, 1); wp_n = 1; req(0, 0); req(1, 0);
    cur = "R6"; cmd(0, 131); cmd(0, 132); cmd(0, 133); boot_top = 1; wp_n = 0;
    req(132, 0); req(133, 1); req(131, 0); req(0, 1); req(1, 0);
    wp_n = 1; req(133, 0); boot_top = 0; req(133, 1);
    cur = "R7"; acc_n = 0; req(5, 0); req(70, 1); req(131, 0); acc_n = 1; req(5, 0);
    cur = "R8"; req(6, 0); req(5, 0, 0); req(5, 1, 0); req(6, 0, 0); cyc();
    cur = "R9"; op_ready = 0; req(5, 1); req(70, 0); req(70, 0); cyc();
    op_ready = 1; req(70, 0); op_ready = 0; req(2, 1); op_ready = 1; cyc(); cyc();
    cur = "R10"; req(6, 0); req(5, 0); req(6, 1); req(7, 0, 0);
    cur = "R11"; req(134, 0); req(200, 1); req(255, 0); cmd(0, 255); req(255, 0);
    cur = "R12";
    cmd_valid = 1; cmd_lock = 1; cmd_sector = 5; req_valid = 1; req_armed = 1; req_sector = 5; req_erase = 0; cyc();
    req(5, 0);
    cmd_valid = 1; cmd_lock = 0; cmd_sector = 9; req_valid = 1; req_armed = 1; req_sector = 9; req_erase = 1; cyc();
    req(9, 1); cyc();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule